// File: doc/BRIEF.md
# I2C Target Write Front End for a Block-Addressed Byte Memory

This block sits between an I2C bus and the write buffer of an 11-bit-addressed byte memory. It samples oversampled SCL and SDA lines and recognises START and STOP conditions. After a START it shifts in a control byte and compares the chip-select field with three strap pins. One of these select bits matches only when it is the inverse of its strap. Three further control bits become the top of the memory address. The next byte sets the low eight address bits, and every byte after that goes to the write buffer as an address/data pair. The block pulls SDA low in the ninth clock of each byte it accepts.

A STOP that ends a write carrying data raises a one-cycle commit pulse, which starts the internal write cycle. While that cycle runs (`wr_busy` high), the block acknowledges nothing. A matched read request is acknowledged and flagged on `rd_req`, and the block then goes idle. Returning read data, clock stretching, 10-bit addressing and arbitration are not provided.

States:
- `S_IDLE` waits for a START.
- `S_CTRL`, `S_ADDR` and `S_DATA` shift in a byte.
- `S_ACKW` waits for SCL to fall after the eighth bit and decides whether to accept the byte.
- `S_ACK` holds SDA low through the ninth clock.

Transitions:
- START from any state goes to `S_CTRL`.
- STOP from any state goes to `S_IDLE`.
- A receive state goes to `S_ACKW` on the eighth SCL rise.
- `S_ACKW` goes to `S_ACK` on SCL fall if the byte is accepted, and to `S_IDLE` otherwise.
- `S_ACK` goes on SCL fall to `S_ADDR` after a write control byte, to `S_DATA` after an address or data byte, and to `S_IDLE` after a read control byte.

Top module: `i2c_eeprom_wfront`

## Requirements
- R1: SDA falling while SCL is high is a START and starts control-byte reception from bit 0 in any state, including in the middle of a byte. SDA rising while SCL is high is a STOP and returns the block to idle.
- R2: The control byte, MSB first, is matched only when bit 7 is 1, bit 6 equals `strap_sel[2]`, bit 5 equals the inverse of `strap_sel[1]` and bit 4 equals `strap_sel[0]`. A mismatch gets no acknowledge, and every following byte is ignored until the next START.
- R3: For each accepted byte, `sda_oe` is 1 through the ninth SCL clock and 0 otherwise. It changes only while SCL is low.
- R4: Control-byte bits 3:1 of a matched write become address bits 10:8.
- R5: The byte after a matched write control byte becomes address bits 7:0.
- R6: Each later accepted byte gives a one-cycle `wr_valid` pulse with `wr_data` set to the byte and `wr_addr` set to the current pointer. The pointer's low 4 bits then increment and wrap from 0xF to 0x0, while bits 10:4 stay constant.
- R7: A STOP after at least one data byte of the current transaction gives a one-cycle `wr_commit` pulse. A STOP with no data byte gives none.
- R8: A matched control byte with bit 0 = 1 is acknowledged and gives a one-cycle `rd_req` pulse. It produces no `wr_valid`.
- R9: While `wr_busy` is 1, no byte is acknowledged and no `wr_valid` is produced, including for a matching control byte.
- R10: After reset, `sda_oe`, `wr_valid`, `wr_commit` and `rd_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | I2C clock line as seen on the pad |
| sda_in | input | 1 | I2C data line as seen on the pad |
| strap_sel | input | 3 | Chip-select strap pins |
| wr_busy | input | 1 | Internal write cycle in progress |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| wr_addr | output | 11 | Memory address of the delivered data byte |
| wr_data | output | 8 | Delivered data byte |
| wr_valid | output | 1 | One-cycle strobe for `wr_addr` / `wr_data` |
| wr_commit | output | 1 | One-cycle strobe: write transaction ended by STOP |
| rd_req | output | 1 | One-cycle strobe: matched read request |

## Verification
Control bytes are tried against two strap settings. These include a byte whose A1 bit equals its strap rather than its inverse, and one with the MSB clear, which shows whether the inverted compare and the leading-one check are both present.

Writes of one byte and of four bytes starting at offset 0xE show whether only the low four pointer bits advance and wrap while the block bits hold. A write cut off by a repeated START three bits into a data byte shows that the partial byte is dropped and the bit count restarts.

A write with no data byte separates commit from address loading. A read request shows the flag without data, and a request made while busy shows that even a matching control byte goes unanswered.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CTRL,
        S_ADDR,
        S_DATA,
        S_ACKW,
        S_ACK
    } state_t;

    typedef enum logic [1:0] {
        PH_CTRL,
        PH_ADDR,
        PH_DATA,
        PH_READ
    } phase_t;

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int N_LINES = 2,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] din,
    output logic [N_LINES-1:0] cur,
    output logic [N_LINES-1:0] prev
);

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        logic              last;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= '1;
                last <= 1'b1;
            end else begin
                pipe <= {pipe[STAGES-2:0], din[g]};
                last <= pipe[STAGES-1];
            end
        end

        assign cur[g]  = pipe[STAGES-1];
        assign prev[g] = last;
    end

endmodule

// File: rtl/i2cw_shifter.sv
module i2cw_shifter #(
    parameter int W     = 8,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [W-1:0]     data,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            cnt  <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (shift_en) begin
            data <= {data[W-2:0], bit_in};
            cnt  <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/i2c_eeprom_wfront.sv
module i2c_eeprom_wfront
    import i2cw_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int BLK_W     = 3,
    parameter int PAGE_BITS = 4,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        strap_sel,
    input  logic              wr_busy,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_valid,
    output logic              wr_commit,
    output logic              rd_req
);

    localparam int LOW_W = ADDR_W - BLK_W;
    localparam int CNT_W = $clog2(LOW_W + 1);

    state_t state, nxt;
    phase_t phase;

    logic [1:0] ln_cur, ln_prev;
    logic scl_c, scl_p, sda_c, sda_p;
    logic scl_rise, scl_fall, start_c, stop_c;
    logic receiving, byte_last, ctrl_match, take, accept;
    logic [LOW_W-1:0] sh_data;
    logic [CNT_W-1:0] sh_cnt;
    logic [ADDR_W-1:0] ptr;
    logic have_data;

    i2cw_sync #(.N_LINES(2), .STAGES(SYNC_STG)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din ({scl_in, sda_in}),
        .cur (ln_cur),
        .prev (ln_prev)
    );

    assign scl_c = ln_cur[1];
    assign sda_c = ln_cur[0];
    assign scl_p = ln_prev[1];
    assign sda_p = ln_prev[0];

    assign scl_rise = scl_c & ~scl_p;
    assign scl_fall = ~scl_c & scl_p;
    assign start_c  = scl_c & scl_p & sda_p & ~sda_c;
    assign stop_c   = scl_c & scl_p & ~sda_p & sda_c;

    assign receiving = (state == S_CTRL) || (state == S_ADDR) || (state == S_DATA);

    i2cw_shifter #(.W(LOW_W)) u_shift (
        .clk (clk),
        .rst_n (rst_n),
        .clr (start_c | ~receiving),
        .shift_en (scl_rise & receiving),
        .bit_in (sda_c),
        .data (sh_data),
        .cnt (sh_cnt)
    );

    assign byte_last  = scl_rise && receiving && (sh_cnt == CNT_W'(LOW_W - 1));
    assign ctrl_match = sh_data[7] && (sh_data[6] == strap_sel[2]) &&
                        (sh_data[5] != strap_sel[1]) && (sh_data[4] == strap_sel[0]);
    assign take       = !wr_busy && ((phase != PH_CTRL) || ctrl_match);
    assign accept     = (state == S_ACKW) && scl_fall && take && !start_c && !stop_c;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (stop_c) begin
            nxt = S_IDLE;
        end else if (start_c) begin
            nxt = S_CTRL;
        end else begin
            unique case (state)
                S_IDLE: nxt = S_IDLE;
                S_CTRL, S_ADDR, S_DATA: if (byte_last) nxt = S_ACKW;
                S_ACKW: if (scl_fall) nxt = take ? S_ACK : S_IDLE;
                S_ACK: if (scl_fall) begin
                    unique case (phase)
                        PH_READ: nxt = S_IDLE;
                        PH_ADDR: nxt = S_ADDR;
                        PH_DATA: nxt = S_DATA;
                        PH_CTRL: nxt = S_IDLE;
                    endcase
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        sda_oe = (state == S_ACK);
    end

    // Byte actions and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= PH_CTRL;
            ptr       <= '0;
            have_data <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_valid  <= 1'b0;
            wr_commit <= 1'b0;
            rd_req    <= 1'b0;
        end else begin
            wr_valid  <= 1'b0;
            wr_commit <= 1'b0;
            rd_req    <= 1'b0;
            if (stop_c) begin
                wr_commit <= have_data;
                have_data <= 1'b0;
                phase     <= PH_CTRL;
            end else if (start_c) begin
                have_data <= 1'b0;
                phase     <= PH_CTRL;
            end else if (accept) begin
                unique case (phase)
                    PH_CTRL: begin
                        ptr[ADDR_W-1:LOW_W] <= sh_data[BLK_W:1];
                        phase  <= sh_data[0] ? PH_READ : PH_ADDR;
                        rd_req <= sh_data[0];
                    end
                    PH_ADDR: begin
                        ptr[LOW_W-1:0] <= sh_data;
                        phase <= PH_DATA;
                    end
                    PH_DATA: begin
                        wr_addr   <= ptr;
                        wr_data   <= sh_data;
                        wr_valid  <= 1'b1;
                        have_data <= 1'b1;
                        ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + PAGE_BITS'(1);
                    end
                    PH_READ: phase <= PH_READ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_eeprom_wfront_chk.sv
module i2c_eeprom_wfront_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_oe,
    input logic wr_busy,
    input logic wr_valid,
    input logic wr_commit,
    input logic rd_req
);

    // R3
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_in);

    // R9
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !$past(wr_busy));

    // R6
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R7
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R1
    commit_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> scl_in);

    // R8
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, wr_commit, rd_req}));

endmodule

bind i2c_eeprom_wfront i2c_eeprom_wfront_chk u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .scl_in (scl_in),
    .sda_oe (sda_oe),
    .wr_busy (wr_busy),
    .wr_valid (wr_valid),
    .wr_commit (wr_commit),
    .rd_req (rd_req)
);

// File: tb/i2c_eeprom_wfront_tb.sv
module i2c_eeprom_wfront_tb;

    localparam int CLK_PERIOD = 10;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic busy = 1'b0;
    logic sda_oe, wr_valid, wr_commit, rd_req;
    logic [10:0] wr_addr;
    logic [7:0] wr_data;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    int n_valid = 0;
    int n_commit = 0;
    int n_rd = 0;
    logic [10:0] log_addr [0:15];
    logic [7:0]  log_data [0:15];

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_eeprom_wfront u_dut (
        .clk (clk),
        .rst_n (rst_n),
        .scl_in (scl_m),
        .sda_in (sda_bus),
        .strap_sel (strap),
        .wr_busy (busy),
        .sda_oe (sda_oe),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_valid (wr_valid),
        .wr_commit (wr_commit),
        .rd_req (rd_req)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                if (n_valid < 16) begin
                    log_addr[n_valid] = wr_addr;
                    log_data[n_valid] = wr_data;
                end
                n_valid++;
            end
            if (wr_commit) n_commit++;
            if (rd_req) n_rd++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clear_log();
        n_valid = 0;
        n_commit = 0;
        n_rd = 0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
        wait_q();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wait_q();
            scl_m = 1'b1; wait_q(); wait_q();
            scl_m = 1'b0; wait_q();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        ack = !sda_bus;
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    // R10
    task automatic t_reset();
        check(sda_oe == 1'b0, "R10 sda_oe after reset", sda_oe, 0);
        check({wr_valid, wr_commit, rd_req} == 3'b000, "R10 strobes after reset",
              {wr_valid, wr_commit, rd_req}, 0);
    endtask

    // R2 R3 R4 R5 R6 R7: single byte write, block 2
    task automatic t_byte_write();
        logic a0, a1, a2;
        clear_log();
        strap = 3'b101;
        bus_start();
        send_byte(8'hF4, a0);
        send_byte(8'h35, a1);
        send_byte(8'hA7, a2);
        check(a0 && a1 && a2, "R3 ack on control/address/data", {a0, a1, a2}, 3'b111);
        check(sda_oe == 1'b0, "R3 sda released after ninth clock", sda_oe, 0);
        bus_stop();
        check(n_valid == 1, "R6 one data strobe", n_valid, 1);
        check(log_addr[0] == 11'h235, "R4 R5 address block and low byte", log_addr[0], 11'h235);
        check(log_data[0] == 8'hA7, "R6 data byte", log_data[0], 8'hA7);
        check(n_commit == 1, "R7 commit after STOP", n_commit, 1);
    endtask

    // R6: page wrap, upper bits constant
    task automatic t_page_wrap();
        logic a;
        logic [10:0] exp_a [0:3];
        exp_a = '{11'h50E, 11'h50F, 11'h500, 11'h501};
        clear_log();
        bus_start();
        send_byte(8'hFA, a);
        send_byte(8'h0E, a);
        for (int i = 0; i < 4; i++) send_byte(8'h10 + 8'(i), a);
        bus_stop();
        check(n_valid == 4, "R6 four data strobes", n_valid, 4);
        for (int i = 0; i < 4; i++) begin
            check(log_addr[i] == exp_a[i], "R6 wrapped address", log_addr[i], exp_a[i]);
            check(log_data[i] == 8'h10 + 8'(i), "R6 page data", log_data[i], 8'h10 + 8'(i));
        end
        check(n_commit == 1, "R7 commit after page write", n_commit, 1);
    endtask

    // R2: A1 not inverted, and MSB clear
    task automatic t_mismatch();
        logic a0, a1, a2;
        clear_log();
        bus_start();
        send_byte(8'hD4, a0);
        send_byte(8'h10, a1);
        send_byte(8'h55, a2);
        bus_stop();
        check(!a0 && !a1 && !a2, "R2 no ack with A1 equal to strap", {a0, a1, a2}, 0);
        check(n_valid == 0 && n_commit == 0, "R2 no strobes after mismatch", n_valid + n_commit, 0);
        bus_start();
        send_byte(8'h74, a0);
        bus_stop();
        check(!a0, "R2 no ack with MSB clear", a0, 0);
        strap = 3'b010;
        bus_start();
        send_byte(8'h8C, a0);
        send_byte(8'h77, a1);
        send_byte(8'h99, a2);
        bus_stop();
        check(a0 && a1 && a2, "R2 match under second strap", {a0, a1, a2}, 3'b111);
        check(n_valid == 1 && log_addr[0] == 11'h677, "R2 R4 address under second strap", log_addr[0], 11'h677);
        strap = 3'b101;
    endtask

    // R8
    task automatic t_read();
        logic a;
        clear_log();
        bus_start();
        send_byte(8'hF5, a);
        check(a, "R8 read control acknowledged", a, 1);
        bus_stop();
        check(n_rd == 1, "R8 read request flagged", n_rd, 1);
        check(n_valid == 0 && n_commit == 0, "R8 no write strobes on read", n_valid + n_commit, 0);
    endtask

    // R9
    task automatic t_busy();
        logic a0, a1;
        clear_log();
        busy = 1'b1;
        bus_start();
        send_byte(8'hF4, a0);
        send_byte(8'h01, a1);
        bus_stop();
        busy = 1'b0;
        check(!a0 && !a1, "R9 silent while busy", {a0, a1}, 0);
        check(n_valid == 0 && n_commit == 0, "R9 no strobes while busy", n_valid + n_commit, 0);
    endtask

    // R1: repeated START in mid byte
    task automatic t_restart();
        logic a;
        clear_log();
        bus_start();
        send_byte(8'hF2, a);
        send_byte(8'h20, a);
        send_bits(8'hE0, 3);
        bus_start();
        send_byte(8'hF6, a);
        send_byte(8'h4F, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        bus_stop();
        check(n_valid == 2, "R1 partial byte dropped at repeated START", n_valid, 2);
        check(log_addr[0] == 11'h34F && log_addr[1] == 11'h340, "R1 R6 addresses after repeated START",
              {log_addr[0], log_addr[1]}, {11'h34F, 11'h340});
        check(log_data[1] == 8'h22, "R1 data after repeated START", log_data[1], 8'h22);
    endtask

    // R7: STOP without data
    task automatic t_no_data();
        logic a;
        clear_log();
        bus_start();
        send_byte(8'hF4, a);
        send_byte(8'h08, a);
        bus_stop();
        check(n_commit == 0, "R7 no commit without data", n_commit, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_byte_write();
        t_page_wrap();
        t_mismatch();
        t_read();
        t_busy();
        t_restart();
        t_no_data();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule